// File: doc/BRIEF.md
# PHY Basic Control Register

This block holds the basic control word of an Ethernet PHY and exposes it on a simple management port (register address, write strobe with write data, read strobe with read data). A management frame decoder sits in front of it and turns serial transactions into single-cycle strobes. The block decodes one register address. It keeps the loopback, speed, auto-negotiation enable, low-power, isolate, duplex and collision-test fields, and drives each of them to the rest of the PHY as a level.

Writing the reset bit starts a timed soft reset. The fields return to their defaults, the auto-negotiation restart request is dropped, and a reset-active output holds the other PHY state machines idle. While that output is high, all management writes are discarded, and reads of the register show the reset bit as 1. Writing the restart bit sends a one-cycle pulse to the auto-negotiation engine. The bit then reads as 1 until that engine acknowledges. The isolate default comes from the strapped PHY address.

Top module: `phy_ctrl_reg`

## Requirements
- R1: After reset (rst_n low at a clock edge) the fields read as speed (bit 13) = 1 and auto-negotiation enable (bit 12) = 1. Isolate (bit 10) = 1 exactly when phy_addr_strap is 0. Loopback (14), low power (11), duplex (8) and collision test (7) read 0. The word is therefore 0x3400 with strap 0, and 0x3000 otherwise.
- R2: A write to the register with bit 15 set reloads the R1 defaults and raises soft_rst_active in the next cycle. soft_rst_active stays high for exactly SRST_CYCLES cycles and then falls.
- R3: While soft_rst_active is high, every write strobe is discarded and the control outputs do not change.
- R4: Bit 15 reads as 1 while soft_rst_active is high and as 0 at all other times.
- R5: Bits 6..0 always read 0. Values written to them are discarded.
- R6: A write with bit 15 clear stores bits 14, 13, 12, 11, 10, 8 and 7. These appear one cycle later on ctl_loopback, ctl_speed100, ctl_an_enable, ctl_low_power, ctl_isolate, ctl_full_duplex and ctl_col_test, and they read back at the same positions.
- R7: A write with bit 9 set (and bit 15 clear) raises an_restart_pulse for exactly the next cycle. Bit 9 then reads 1 until an_ack is seen, and reads 0 from the cycle after the ack. Writing bit 9 as 0 does not clear a pending restart.
- R8: A write to any address other than REG_ADDR changes nothing. mgmt_rdata is 0 unless mgmt_rd is high and mgmt_addr equals REG_ADDR. The read is combinational in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_addr_strap | input | 5 | Strapped PHY address, used for the isolate default |
| mgmt_addr | input | 5 | Register address of the access |
| mgmt_wr | input | 1 | Write strobe |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rd | input | 1 | Read strobe |
| mgmt_rdata | output | 16 | Read data |
| an_ack | input | 1 | Acknowledge from the auto-negotiation engine |
| ctl_loopback | output | 1 | Loopback enable |
| ctl_speed100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| ctl_an_enable | output | 1 | Auto-negotiation enable |
| ctl_low_power | output | 1 | Low-power mode |
| ctl_isolate | output | 1 | Isolate from the MAC interface |
| ctl_full_duplex | output | 1 | 1 = full duplex |
| ctl_col_test | output | 1 | Collision test enable |
| an_restart_pulse | output | 1 | One-cycle auto-negotiation restart request |
| soft_rst_active | output | 1 | Soft reset in progress; holds PHY state machines idle |

## Verification
The assertions check five things on every cycle: the reserved bits read 0, reads outside the register return 0, bit 15 reads as 1 during soft reset, and the controls stay frozen and every restart pulse has a matching write. They also check that the defaults are present when a soft reset begins. The exact length of the soft reset and the dependence of isolate on the strap can only be shown by the bench's scenarios. The same holds for clearing a pending restart by acknowledge but not by writing 0, and for write data reaching the outputs. The bench compares all of these against its reference model every clock.

// File: rtl/phy_ctrl_pkg.sv
`timescale 1ns/1ps
package phy_ctrl_pkg;

    localparam int WORD_W  = 16;
    localparam int PHYAD_W = 5;

    // Bit positions of the control word (decoded by management software)
    localparam int B_SRST = 15;
    localparam int B_LOOP = 14;
    localparam int B_SPD  = 13;
    localparam int B_ANEN = 12;
    localparam int B_LPWR = 11;
    localparam int B_ISO  = 10;
    localparam int B_ANRS = 9;
    localparam int B_DPX  = 8;
    localparam int B_COL  = 7;

    typedef struct packed {
        logic loopback;
        logic speed100;
        logic an_en;
        logic low_pwr;
        logic isolate;
        logic full_dpx;
        logic col_test;
    } ctrl_fields_t;

    function automatic ctrl_fields_t ctrl_defaults(input logic [PHYAD_W-1:0] strap);
        ctrl_fields_t f;
        f.loopback = 1'b0;
        f.speed100 = 1'b1;
        f.an_en    = 1'b1;
        f.low_pwr  = 1'b0;
        f.isolate  = (strap == '0);
        f.full_dpx = 1'b0;
        f.col_test = 1'b0;
        return f;
    endfunction

    function automatic ctrl_fields_t fields_from_word(input logic [WORD_W-1:0] w);
        ctrl_fields_t f;
        f.loopback = w[B_LOOP];
        f.speed100 = w[B_SPD];
        f.an_en    = w[B_ANEN];
        f.low_pwr  = w[B_LPWR];
        f.isolate  = w[B_ISO];
        f.full_dpx = w[B_DPX];
        f.col_test = w[B_COL];
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] word_from_fields(input ctrl_fields_t f,
                                                           input logic busy,
                                                           input logic an_pend);
        logic [WORD_W-1:0] w;
        w         = '0;
        w[B_SRST] = busy;
        w[B_LOOP] = f.loopback;
        w[B_SPD]  = f.speed100;
        w[B_ANEN] = f.an_en;
        w[B_LPWR] = f.low_pwr;
        w[B_ISO]  = f.isolate;
        w[B_ANRS] = an_pend;
        w[B_DPX]  = f.full_dpx;
        w[B_COL]  = f.col_test;
        return w;
    endfunction

endpackage

// File: rtl/phy_ctrl_srst_timer.sv
`timescale 1ns/1ps
module phy_ctrl_srst_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_LOAD;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;

endmodule

// File: rtl/phy_ctrl_an_tracker.sv
`timescale 1ns/1ps
module phy_ctrl_an_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic set,
    input  logic ack,
    output logic pending,
    output logic pulse
);
    typedef struct packed {
        logic pend;
        logic pulse;
    } an_state_t;

    an_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (clear) begin
            st_d.pend = 1'b0;
        end else if (set) begin
            st_d.pend  = 1'b1;
            st_d.pulse = 1'b1;
        end else if (ack) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending = st_q.pend;
    assign pulse   = st_q.pulse;

endmodule

// File: rtl/phy_ctrl_reg.sv
`timescale 1ns/1ps
module phy_ctrl_reg
    import phy_ctrl_pkg::*;
#(
    parameter int               SRST_CYCLES = 16,
    parameter logic [4:0]       REG_ADDR    = 5'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  phy_addr_strap,
    input  logic [4:0]  mgmt_addr,
    input  logic        mgmt_wr,
    input  logic [15:0] mgmt_wdata,
    input  logic        mgmt_rd,
    output logic [15:0] mgmt_rdata,
    input  logic        an_ack,
    output logic        ctl_loopback,
    output logic        ctl_speed100,
    output logic        ctl_an_enable,
    output logic        ctl_low_power,
    output logic        ctl_isolate,
    output logic        ctl_full_duplex,
    output logic        ctl_col_test,
    output logic        an_restart_pulse,
    output logic        soft_rst_active
);
    logic         busy;
    logic         an_pend;
    logic         wr_hit;
    logic         srst_start;
    logic         field_wr;
    logic         rd_hit;
    ctrl_fields_t fld_d, fld_q;

    assign wr_hit     = mgmt_wr && (mgmt_addr == REG_ADDR) && !busy;
    assign srst_start = wr_hit && mgmt_wdata[B_SRST];
    assign field_wr   = wr_hit && !mgmt_wdata[B_SRST];
    assign rd_hit     = mgmt_rd && (mgmt_addr == REG_ADDR);

    phy_ctrl_srst_timer #(
        .CYCLES (SRST_CYCLES)
    ) u_srst (
        .clk   (clk),
        .rst_n (rst_n),
        .start (srst_start),
        .busy  (busy)
    );

    phy_ctrl_an_tracker u_an (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (srst_start),
        .set     (field_wr && mgmt_wdata[B_ANRS]),
        .ack     (an_ack),
        .pending (an_pend),
        .pulse   (an_restart_pulse)
    );

    always_comb begin
        fld_d = fld_q;
        if (srst_start) begin
            fld_d = ctrl_defaults(phy_addr_strap);
        end else if (field_wr) begin
            fld_d = fields_from_word(mgmt_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q <= ctrl_defaults(phy_addr_strap);
        end else begin
            fld_q <= fld_d;
        end
    end

    assign mgmt_rdata      = rd_hit ? word_from_fields(fld_q, busy, an_pend) : '0;
    assign ctl_loopback    = fld_q.loopback;
    assign ctl_speed100    = fld_q.speed100;
    assign ctl_an_enable   = fld_q.an_en;
    assign ctl_low_power   = fld_q.low_pwr;
    assign ctl_isolate     = fld_q.isolate;
    assign ctl_full_duplex = fld_q.full_dpx;
    assign ctl_col_test    = fld_q.col_test;
    assign soft_rst_active = busy;

endmodule

// File: rtl/phy_ctrl_reg_chk.sv
`timescale 1ns/1ps
module phy_ctrl_reg_chk #(
    parameter logic [4:0] REG_ADDR = 5'd0
) (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  phy_addr_strap,
    input logic [4:0]  mgmt_addr,
    input logic        mgmt_wr,
    input logic [15:0] mgmt_wdata,
    input logic        mgmt_rd,
    input logic [15:0] mgmt_rdata,
    input logic        ctl_loopback,
    input logic        ctl_speed100,
    input logic        ctl_an_enable,
    input logic        ctl_low_power,
    input logic        ctl_isolate,
    input logic        ctl_full_duplex,
    input logic        ctl_col_test,
    input logic        an_restart_pulse,
    input logic        soft_rst_active
);
    logic [6:0] ctl_vec;
    assign ctl_vec = {ctl_loopback, ctl_speed100, ctl_an_enable, ctl_low_power,
                      ctl_isolate, ctl_full_duplex, ctl_col_test};

    a_r2_defaults_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst_active) |-> (ctl_speed100 && ctl_an_enable && !ctl_loopback &&
            !ctl_low_power && !ctl_full_duplex && !ctl_col_test &&
            (ctl_isolate == (phy_addr_strap == 5'd0))));

    a_r3_frozen_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_active |=> $stable(ctl_vec));

    a_r4_busy_reads_set: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_active && mgmt_rd && mgmt_addr == REG_ADDR) |-> mgmt_rdata[15]);

    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_rdata[6:0] == 7'd0);

    a_r7_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart_pulse |-> $past(mgmt_wr && mgmt_addr == REG_ADDR && mgmt_wdata[9] &&
                                   !mgmt_wdata[15] && !soft_rst_active));

    a_r8_unaddressed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(mgmt_rd && mgmt_addr == REG_ADDR) |-> mgmt_rdata == 16'd0);

endmodule

bind phy_ctrl_reg phy_ctrl_reg_chk #(.REG_ADDR(REG_ADDR)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .phy_addr_strap   (phy_addr_strap),
    .mgmt_addr        (mgmt_addr),
    .mgmt_wr          (mgmt_wr),
    .mgmt_wdata       (mgmt_wdata),
    .mgmt_rd          (mgmt_rd),
    .mgmt_rdata       (mgmt_rdata),
    .ctl_loopback     (ctl_loopback),
    .ctl_speed100     (ctl_speed100),
    .ctl_an_enable    (ctl_an_enable),
    .ctl_low_power    (ctl_low_power),
    .ctl_isolate      (ctl_isolate),
    .ctl_full_duplex  (ctl_full_duplex),
    .ctl_col_test     (ctl_col_test),
    .an_restart_pulse (an_restart_pulse),
    .soft_rst_active  (soft_rst_active)
);

// File: tb/phy_ctrl_reg_tb.sv
`timescale 1ns/1ps
module phy_ctrl_reg_tb;
    localparam int SRST = 16;
    localparam logic [15:0] WMASK = 16'h7D80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap = 5'd0;
    logic [4:0]  addr = 5'd0;
    logic        wr = 1'b0;
    logic [15:0] wdata = 16'd0;
    logic        rd = 1'b0;
    logic [15:0] rdata;
    logic        ack = 1'b0;
    logic        c_lb, c_spd, c_an, c_lp, c_iso, c_fd, c_col, pulse, active;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [15:0] m_reg = 16'h0;
    bit          m_busy = 1'b0;
    int          m_cnt = 0;
    bit          m_pend = 1'b0;
    bit          m_pulse = 1'b0;

    always #2.5 clk = ~clk;

    phy_ctrl_reg #(.SRST_CYCLES(SRST), .REG_ADDR(5'd0)) u_dut (
        .clk (clk), .rst_n (rst_n), .phy_addr_strap (strap),
        .mgmt_addr (addr), .mgmt_wr (wr), .mgmt_wdata (wdata), .mgmt_rd (rd),
        .mgmt_rdata (rdata), .an_ack (ack),
        .ctl_loopback (c_lb), .ctl_speed100 (c_spd), .ctl_an_enable (c_an),
        .ctl_low_power (c_lp), .ctl_isolate (c_iso), .ctl_full_duplex (c_fd),
        .ctl_col_test (c_col), .an_restart_pulse (pulse), .soft_rst_active (active)
    );

    function automatic logic [15:0] dflt(input logic [4:0] s);
        return 16'h3000 | ((s == 5'd0) ? 16'h0400 : 16'h0000);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        bit hit;
        hit = wr && addr == 5'd0 && !m_busy;
        m_pulse = 1'b0;
        if (!rst_n) begin
            m_reg = dflt(strap); m_busy = 0; m_cnt = 0; m_pend = 0;
        end else begin
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) m_busy = 0;
            end
            if (hit && wdata[15]) begin
                m_reg = dflt(strap); m_busy = 1; m_cnt = SRST; m_pend = 0;
            end else if (hit && wdata[9]) begin
                m_reg = wdata & WMASK; m_pend = 1; m_pulse = 1'b1;
            end else begin
                if (hit) m_reg = wdata & WMASK;
                if (ack) m_pend = 0;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        logic [15:0] exp_rd;
        if (rst_n && !done) begin
            exp_rd = (rd && addr == 5'd0) ? (m_reg | {m_busy, 15'd0} | (m_pend ? 16'h0200 : 16'h0)) : 16'h0;
            chk((rd && addr != 5'd0) ? "R8" : (m_busy ? "R4" : "R6"), rdata, exp_rd);
            chk("R5", {9'd0, rdata[6:0]}, 16'd0);
            chk("R6", {9'd0, c_lb, c_spd, c_an, c_lp, c_iso, c_fd, c_col},
                {9'd0, m_reg[14], m_reg[13], m_reg[12], m_reg[11], m_reg[10], m_reg[8], m_reg[7]});
            chk("R7", {15'd0, pulse}, {15'd0, m_pulse});
            chk("R2", {15'd0, active}, {15'd0, m_busy});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick(1);
        wr = 1'b0; wdata = 16'h0; addr = 5'd0;
    endtask

    task automatic rd_expect(input string req, input logic [4:0] a, input logic [15:0] exp);
        addr = a; rd = 1'b1;
        #0.5;
        chk(req, rdata, exp);
        tick(1);
        rd = 1'b0; addr = 5'd0;
    endtask

    task automatic do_reset(input logic [4:0] s);
        strap = s; rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    initial begin
        tick(1);
        // R1: defaults with strap zero, then non-zero
        do_reset(5'd0);
        rd_expect("R1", 5'd0, 16'h3400);

        // R6: store fields
        wr_reg(5'd0, 16'h4980);
        rd_expect("R6", 5'd0, 16'h4980);
        wr_reg(5'd0, 16'h2500);
        rd_expect("R6", 5'd0, 16'h2500);

        // R5: reserved bits discarded
        wr_reg(5'd0, 16'h307F);
        rd_expect("R5", 5'd0, 16'h3000);

        // R8: other address ignored, reads zero
        wr_reg(5'd3, 16'h4000);
        rd_expect("R8", 5'd0, 16'h3000);
        rd_expect("R8", 5'd3, 16'h0000);

        // R7: restart pulse and pending until ack
        wr_reg(5'd0, 16'h1200);
        rd_expect("R7", 5'd0, 16'h1200);
        wr_reg(5'd0, 16'h1000);
        rd_expect("R7", 5'd0, 16'h1200);
        ack = 1'b1; tick(1); ack = 1'b0;
        rd_expect("R7", 5'd0, 16'h1000);

        // R2/R3/R4: soft reset with a pending restart and writes dropped
        wr_reg(5'd0, 16'h4300);
        wr_reg(5'd0, 16'h8000);
        rd_expect("R4", 5'd0, 16'hB400);
        wr_reg(5'd0, 16'h4100);
        rd_expect("R3", 5'd0, 16'hB400);
        tick(SRST - 4);
        rd_expect("R4", 5'd0, 16'hB400);
        rd_expect("R2", 5'd0, 16'h3400);
        wr_reg(5'd0, 16'h0100);
        rd_expect("R6", 5'd0, 16'h0100);

        // R1: non-zero strap clears isolate default
        do_reset(5'd5);
        rd_expect("R1", 5'd0, 16'h3000);
        wr_reg(5'd0, 16'h8000);
        tick(SRST + 2);
        rd_expect("R2", 5'd0, 16'h3000);

        tick(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule